// File: doc/BRIEF.md
# Configurable Port Logic Gate Array

This block turns groups of four port pins into small real-time logic gates. In each group, offsets 0 to 2 are gate inputs and offset 3 is the gate output. A group is programmed either as any function of up to three inputs, through an eight-entry truth table, or as a two-input XOR/XNOR. Each input has its own use bit. An input whose use bit is clear reads as 0 inside the gate, and its pin stays an ordinary port.

Groups are paired: group 2p feeds group 2p+1. When cascading is switched on for a pair and both groups are enabled, the first group's result takes the place of the second group's input 0. This forms a two-level gate. A visibility bit decides whether the intermediate term still drives its own pin or stays internal. Pad levels pass through a reset-cleared synchroniser. The gates are purely combinational from the synchronised levels, so only the synchroniser adds latency. Every synchronised pin level is readable, and every gate result, hidden or not, is readable too.

The surrounding port logic supplies the ordinary per-pin output value and output enable. This block overrides them only on the pins that an enabled gate owns.

Top module: `cfg_gate_array`

## Requirements
- R1: While `rst_n` is low, the synchroniser holds 0, so `rd_pin` is 0. With every group disabled, `pin_out` equals `gpio_out` and `pin_oe` equals `gpio_oe`.
- R2: A level on `pin_in` appears on `rd_pin` after exactly two rising clock edges. Gate results follow the synchronised levels with no further register.
- R3: The per-group config word is 14 bits, with group g at bits [14g+13:14g]. Bits [7:0] hold the truth table and bit 8 is 0 for table mode. In table mode the result is table bit {in2,in1,in0}, where in k is the synchronised level of pin 4g+k.
- R4: With config bit 8 set, the result is in0 XOR in1 XOR config bit 9, so bit 9 = 1 gives XNOR. Input 2 has no effect on the result.
- R5: Config bits [12:10] are use bits for inputs 2..0. A clear use bit forces that input to 0 in the gate, and that pin's `pin_out`/`pin_oe` follow `gpio_out`/`gpio_oe`. A set use bit in an enabled group forces `pin_oe` of that pin to 0.
- R6: For an enabled group whose output is not hidden, the offset-3 pin ignores `gpio_oe`. If config bit 13 is 1 (push-pull), `pin_oe`=1 and `pin_out`=result. If bit 13 is 0 (open drain), `pin_out`=0 and `pin_oe`=NOT result.
- R7: When `grp_en[g]` is 0, all four pins of group g follow `gpio_out`/`gpio_oe` and `term_rd[g]` is 0.
- R8: When `casc_en[p]`, `grp_en[2p]` and `grp_en[2p+1]` are all 1, input 0 of group 2p+1 is the result of group 2p, still subject to its use bit. Pin 8p+4 is then an ordinary port.
- R9: In an active cascade, `mid_vis[p]`=0 returns pin 8p+3 to ordinary port control. `mid_vis[p]`=1 makes that pin drive the intermediate term as in R6.
- R10: `rd_pin` gives the synchronised level of every pin, and `term_rd[g]` gives each gate result, including a hidden intermediate term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the synchroniser |
| pin_in | input | 4*NGROUP | Raw pad levels |
| gpio_out | input | 4*NGROUP | Ordinary port output values |
| gpio_oe | input | 4*NGROUP | Ordinary port output enables |
| grp_en | input | NGROUP | Gate enable per group |
| grp_cfg | input | 14*NGROUP | Packed per-group config words |
| casc_en | input | NGROUP/2 | Cascade enable per group pair |
| mid_vis | input | NGROUP/2 | Intermediate term drives its pin when 1 |
| pin_out | output | 4*NGROUP | Pad output values |
| pin_oe | output | 4*NGROUP | Pad output enables |
| rd_pin | output | 4*NGROUP | Synchronised pin levels |
| term_rd | output | NGROUP | Gate results |

## Verification
Several properties are checked on every cycle:
- pin ownership: used inputs are never driven, unused and disabled pins pass the port control through, and the cascade-freed and hidden pins return to port control;
- the push-pull and open-drain drive of each output pin relative to its readable result;
- the two-edge synchroniser delay;
- a cleared result in a disabled group.

The logic function itself is shown only by the bench scenarios and by its cycle model:
- the truth-table contents;
- XOR against XNOR and the inertness of input 2;
- masking of unused inputs in the index;
- the value that a cascaded two-level gate computes.

// File: rtl/cga_pkg.sv
package cga_pkg;

  localparam int CFG_W = 14;

  // bit 13 push_pull, 12:10 use bits, 9 xnor polarity, 8 xor mode, 7:0 truth table
  typedef struct packed {
    logic       push_pull;
    logic [2:0] use_bits;
    logic       xnor_pol;
    logic       xor_mode;
    logic [7:0] table_bits;
  } grp_cfg_t;

  function automatic logic [2:0] mask_levels(input logic [2:0] lvl, input logic [2:0] use_bits);
    return lvl & use_bits;
  endfunction

  function automatic logic gate_eval(input grp_cfg_t cfg, input logic [2:0] lvl);
    logic [2:0] m;
    m = mask_levels(lvl, cfg.use_bits);
    if (cfg.xor_mode) return m[0] ^ m[1] ^ cfg.xnor_pol;
    return cfg.table_bits[m];
  endfunction

endpackage

// File: rtl/cga_sync.sv
module cga_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cga_gate.sv
module cga_gate
  import cga_pkg::*;
(
  input  grp_cfg_t   cfg,
  input  logic       en,
  input  logic [2:0] pin_lvl,
  input  logic       casc_sel,
  input  logic       casc_lvl,
  output logic [2:0] eff_lvl,
  output logic       result
);
  // input 0 may come from the neighbouring group instead of its pin
  always_comb begin
    eff_lvl = {pin_lvl[2:1], casc_sel ? casc_lvl : pin_lvl[0]};
    result  = en & gate_eval(cfg, eff_lvl);
  end
endmodule

// File: rtl/cga_pin_mux.sv
module cga_pin_mux
  import cga_pkg::*;
(
  input  grp_cfg_t   cfg,
  input  logic       en,
  input  logic       result,
  input  logic       in0_free,
  input  logic       out_hide,
  input  logic [3:0] gpio_out,
  input  logic [3:0] gpio_oe,
  output logic [3:0] pin_out,
  output logic [3:0] pin_oe,
  output logic [3:0] owned
);
  always_comb begin
    owned[0] = en & cfg.use_bits[0] & ~in0_free;
    owned[1] = en & cfg.use_bits[1];
    owned[2] = en & cfg.use_bits[2];
    owned[3] = en & ~out_hide;
    for (int k = 0; k < 3; k++) begin
      pin_out[k] = gpio_out[k];
      pin_oe[k]  = owned[k] ? 1'b0 : gpio_oe[k];
    end
    if (owned[3]) begin
      pin_out[3] = cfg.push_pull ? result : 1'b0;
      pin_oe[3]  = cfg.push_pull ? 1'b1 : ~result;
    end else begin
      pin_out[3] = gpio_out[3];
      pin_oe[3]  = gpio_oe[3];
    end
  end
endmodule

// File: rtl/cfg_gate_array.sv
module cfg_gate_array
  import cga_pkg::*;
#(
  parameter int NGROUP      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NPIN       = 4 * NGROUP,
  localparam int NPAIR      = NGROUP / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPIN-1:0]         pin_in,
  input  logic [NPIN-1:0]         gpio_out,
  input  logic [NPIN-1:0]         gpio_oe,
  input  logic [NGROUP-1:0]       grp_en,
  input  logic [NGROUP*CFG_W-1:0] grp_cfg,
  input  logic [NPAIR-1:0]        casc_en,
  input  logic [NPAIR-1:0]        mid_vis,
  output logic [NPIN-1:0]         pin_out,
  output logic [NPIN-1:0]         pin_oe,
  output logic [NPIN-1:0]         rd_pin,
  output logic [NGROUP-1:0]       term_rd
);
  logic [NPIN-1:0]   s_lvl;
  logic [NPAIR-1:0]  casc_act;
  logic [NGROUP-1:0] casc_sel;
  logic [NGROUP-1:0] casc_lvl;
  logic [NGROUP-1:0] out_hide;
  logic [NGROUP-1:0] result;
  logic [NPIN-1:0]   pin_owned;

  cga_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(s_lvl)
  );

  // cascade decisions per pair
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign casc_act[p] = casc_en[p] & grp_en[2*p] & grp_en[2*p+1];
  end

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    grp_cfg_t   cfg;
    logic [2:0] eff_lvl;
    assign cfg = grp_cfg_t'(grp_cfg[g*CFG_W +: CFG_W]);

    if ((g % 2) == 1) begin : g_second
      assign casc_sel[g] = casc_act[g/2];
      assign casc_lvl[g] = result[g-1];
      assign out_hide[g] = 1'b0;
    end else if (g + 1 < NGROUP) begin : g_first
      assign casc_sel[g] = 1'b0;
      assign casc_lvl[g] = 1'b0;
      assign out_hide[g] = casc_act[g/2] & ~mid_vis[g/2];
    end else begin : g_single
      assign casc_sel[g] = 1'b0;
      assign casc_lvl[g] = 1'b0;
      assign out_hide[g] = 1'b0;
    end

    cga_gate u_gate (
      .cfg(cfg), .en(grp_en[g]), .pin_lvl(s_lvl[4*g +: 3]),
      .casc_sel(casc_sel[g]), .casc_lvl(casc_lvl[g]),
      .eff_lvl(eff_lvl), .result(result[g])
    );

    cga_pin_mux u_mux (
      .cfg(cfg), .en(grp_en[g]), .result(result[g]),
      .in0_free(casc_sel[g]), .out_hide(out_hide[g]),
      .gpio_out(gpio_out[4*g +: 4]), .gpio_oe(gpio_oe[4*g +: 4]),
      .pin_out(pin_out[4*g +: 4]), .pin_oe(pin_oe[4*g +: 4]),
      .owned(pin_owned[4*g +: 4])
    );
  end

  assign rd_pin  = s_lvl;
  assign term_rd = result;

endmodule

// File: rtl/cga_chk.sv
module cga_chk
  import cga_pkg::*;
#(
  parameter int NGROUP      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NPIN       = 4 * NGROUP,
  localparam int NPAIR      = NGROUP / 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPIN-1:0]         pin_in,
  input logic [NPIN-1:0]         gpio_out,
  input logic [NPIN-1:0]         gpio_oe,
  input logic [NGROUP-1:0]       grp_en,
  input logic [NGROUP*CFG_W-1:0] grp_cfg,
  input logic [NPAIR-1:0]        casc_en,
  input logic [NPAIR-1:0]        mid_vis,
  input logic [NPIN-1:0]         pin_out,
  input logic [NPIN-1:0]         pin_oe,
  input logic [NPIN-1:0]         rd_pin,
  input logic [NGROUP-1:0]       term_rd,
  input logic [NPAIR-1:0]        casc_act
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_sync_chk
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seen == 2'd2 |-> rd_pin == $past(pin_in, 2));
  end

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    grp_cfg_t c;
    logic     sec;
    logic     hid;
    assign c = grp_cfg_t'(grp_cfg[g*CFG_W +: CFG_W]);
    if ((g % 2) == 1) begin : g_s
      assign sec = casc_act[g/2];
      assign hid = 1'b0;
    end else if (g + 1 < NGROUP) begin : g_f
      assign sec = 1'b0;
      assign hid = casc_act[g/2] & ~mid_vis[g/2];
    end else begin : g_o
      assign sec = 1'b0;
      assign hid = 1'b0;
    end

    p_off_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_en[g] |-> pin_out[4*g +: 4] == gpio_out[4*g +: 4]
                  && pin_oe[4*g +: 4] == gpio_oe[4*g +: 4] && !term_rd[g]);

    p_push_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en[g] && !hid && c.push_pull |-> pin_oe[4*g+3] && pin_out[4*g+3] == term_rd[g]);

    p_open_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en[g] && !hid && !c.push_pull |-> !pin_out[4*g+3] && pin_oe[4*g+3] == !term_rd[g]);

    p_hidden_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hid |-> pin_oe[4*g+3] == gpio_oe[4*g+3] && pin_out[4*g+3] == gpio_out[4*g+3]);

    p_free_in0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec |-> pin_oe[4*g] == gpio_oe[4*g] && pin_out[4*g] == gpio_out[4*g]);

    for (genvar k = 0; k < 3; k++) begin : g_in
      p_used_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_en[g] && c.use_bits[k] && !(k == 0 && sec) |-> !pin_oe[4*g+k]);
      p_unused_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !c.use_bits[k] |-> pin_oe[4*g+k] == gpio_oe[4*g+k] && pin_out[4*g+k] == gpio_out[4*g+k]);
    end
  end
endmodule

bind cfg_gate_array cga_chk #(.NGROUP(NGROUP), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/sim_cfg_gate_array.sv
module sim_cfg_gate_array;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2;
  localparam int NP = 4 * NG;
  localparam int CW = 14;
  localparam int NPR = NG / 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP-1:0] pin_in = '0, gpio_out = '0, gpio_oe = '0;
  logic [NG-1:0] grp_en = '0;
  logic [NG*CW-1:0] grp_cfg = '0;
  logic [NPR-1:0] casc_en = '0, mid_vis = '0;
  logic [NP-1:0] pin_out, pin_oe, rd_pin;
  logic [NG-1:0] term_rd;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_gate_array #(.NGROUP(NG)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the requirements
  logic [NP-1:0] sq[$];

  task automatic model(input logic [NP-1:0] s, output logic [NP-1:0] eo,
                       output logic [NP-1:0] eoe, output logic [NG-1:0] et);
    logic [CW-1:0] c;
    logic i0, i1, i2, r;
    bit second, hide;
    int idx;
    eo = gpio_out; eoe = gpio_oe; et = '0;
    for (int g = 0; g < NG; g++) begin
      c = grp_cfg[g*CW +: CW];
      second = 0; hide = 0;
      if (g % 2 == 1) second = casc_en[g/2] && grp_en[g-1] && grp_en[g];
      else if (g + 1 < NG) hide = casc_en[g/2] && grp_en[g] && grp_en[g+1] && !mid_vis[g/2];
      i0 = second ? et[g-1] : s[4*g];
      i1 = s[4*g+1]; i2 = s[4*g+2];
      i0 = c[10] ? i0 : 1'b0;
      i1 = c[11] ? i1 : 1'b0;
      i2 = c[12] ? i2 : 1'b0;
      idx = 4 * int'(i2) + 2 * int'(i1) + int'(i0);
      r = c[8] ? (i0 ^ i1 ^ c[9]) : c[idx];
      if (grp_en[g]) begin
        et[g] = r;
        if (c[10] && !second) eoe[4*g] = 0;
        if (c[11]) eoe[4*g+1] = 0;
        if (c[12]) eoe[4*g+2] = 0;
        if (!hide) begin
          eo[4*g+3]  = c[13] ? r : 1'b0;
          eoe[4*g+3] = c[13] ? 1'b1 : !r;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    logic [NP-1:0] s, eo, eoe;
    logic [NG-1:0] et;
    if (!rst_n) sq.delete();
    else begin
      sq.push_back(pin_in);
      if (sq.size() > 2) void'(sq.pop_front());
    end
    #2;
    if (!done) begin
      s = (sq.size() == 2) ? sq[0] : '0;
      model(s, eo, eoe, et);
      chk({cur_req, " rd_pin (R10)"}, 32'(rd_pin), 32'(s));
      chk({cur_req, " pin_out"}, 32'(pin_out), 32'(eo));
      chk({cur_req, " pin_oe"}, 32'(pin_oe), 32'(eoe));
      chk({cur_req, " term_rd"}, 32'(term_rd), 32'(et));
    end
  end

  function automatic logic [CW-1:0] mk(input logic [7:0] tbl, input logic xm, input logic pol,
                                       input logic [2:0] use_b, input logic pp);
    return {pp, use_b, pol, xm, tbl};
  endfunction

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk); pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    gpio_out = 8'hA5; gpio_oe = 8'h3C; pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 rd_pin in reset", 32'(rd_pin), 0);
    chk("R1 pin_out passthru", 32'(pin_out), 32'h A5);
    chk("R1 pin_oe passthru", 32'(pin_oe), 32'h3C);
    rst_n = 1;

    // R2 latency
    cur_req = "R2";
    @(negedge clk); pin_in = 8'h00;
    repeat (2) @(negedge clk);
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk);
    chk("R2 one edge old", 32'(rd_pin), 0);
    @(negedge clk);
    chk("R2 two edges new", 32'(rd_pin), 32'h5A);

    // R7 disabled groups
    cur_req = "R7";
    grp_cfg = {mk(8'hFF, 0, 0, 3'b111, 1), mk(8'hFF, 0, 0, 3'b111, 1)};
    gpio_out = 8'h69; gpio_oe = 8'h96;
    set_pins(8'hFF);
    chk("R7 out", 32'(pin_out), 32'h69);
    chk("R7 oe", 32'(pin_oe), 32'h96);
    chk("R7 term", 32'(term_rd), 0);

    // R3 majority table on group 0
    cur_req = "R3";
    grp_en = 2'b01; gpio_oe = '0;
    grp_cfg[0 +: CW] = mk(8'hE8, 0, 0, 3'b111, 1);
    for (int v = 0; v < 8; v++) begin
      set_pins(NP'(v));
      chk("R3 majority term", 32'(term_rd[0]), 32'(v == 3 || v >= 5));
      chk("R3 majority pin", 32'(pin_out[3]), 32'(v == 3 || v >= 5));
    end

    // R4 xor / xnor on group 1, input 2 inert
    cur_req = "R4";
    grp_en = 2'b10;
    for (int pol = 0; pol < 2; pol++) begin
      grp_cfg[CW +: CW] = mk(8'h00, 1, 1'(pol), 3'b111, 1);
      for (int v = 0; v < 8; v++) begin
        set_pins(NP'(v << 4));
        chk("R4 xor term", 32'(term_rd[1]), 32'((v & 1) ^ ((v >> 1) & 1) ^ pol));
      end
    end

    // R5 unused input masking and pass-through
    cur_req = "R5";
    grp_en = 2'b01;
    grp_cfg[0 +: CW] = mk(8'hFE, 0, 0, 3'b101, 1);
    gpio_out = 8'h02; gpio_oe = 8'h07;
    set_pins(8'h02);
    chk("R5 masked index", 32'(term_rd[0]), 0);
    chk("R5 unused pin oe", 32'(pin_oe[1]), 1);
    chk("R5 unused pin out", 32'(pin_out[1]), 1);
    chk("R5 used pin oe", 32'(pin_oe[0]), 0);
    set_pins(8'h04);
    chk("R5 used in2", 32'(term_rd[0]), 1);

    // R6 drive types, direction ignored
    cur_req = "R6";
    gpio_oe = 8'h00; gpio_out = 8'h00;
    grp_cfg[0 +: CW] = mk(8'h01, 0, 0, 3'b000, 1);
    set_pins(8'h00);
    chk("R6 pp oe", 32'(pin_oe[3]), 1);
    chk("R6 pp out", 32'(pin_out[3]), 1);
    grp_cfg[0 +: CW] = mk(8'h01, 0, 0, 3'b000, 0);
    @(negedge clk);
    chk("R6 od high oe", 32'(pin_oe[3]), 0);
    grp_cfg[0 +: CW] = mk(8'h00, 0, 0, 3'b000, 0);
    @(negedge clk);
    chk("R6 od low oe", 32'(pin_oe[3]), 1);
    chk("R6 od low out", 32'(pin_out[3]), 0);

    // R8 cascade: AND3 into OR2
    cur_req = "R8";
    grp_en = 2'b11; casc_en = 1'b1; mid_vis = 1'b1;
    gpio_oe = 8'h10; gpio_out = 8'h10;
    grp_cfg = {mk(8'hEE, 0, 0, 3'b011, 1), mk(8'h80, 0, 0, 3'b111, 1)};
    set_pins(8'h07);
    chk("R8 two-level high", 32'(term_rd[1]), 1);
    chk("R8 freed pin oe", 32'(pin_oe[4]), 1);
    set_pins(8'h16);
    chk("R8 pin4 ignored", 32'(term_rd[1]), 0);
    set_pins(8'h26);
    chk("R8 in1 path", 32'(term_rd[1]), 1);

    // R9 hidden intermediate, R10 still readable
    cur_req = "R9";
    gpio_oe = 8'h00;
    set_pins(8'h07);
    chk("R9 visible mid oe", 32'(pin_oe[3]), 1);
    mid_vis = 1'b0;
    @(negedge clk);
    chk("R9 hidden mid oe", 32'(pin_oe[3]), 0);
    chk("R10 hidden term readable", 32'(term_rd[0]), 1);

    // random mix against the model
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pin_in = NP'($urandom); gpio_out = NP'($urandom); gpio_oe = NP'($urandom);
      if (i % 8 == 0) begin
        grp_cfg = (NG*CW)'({$urandom, $urandom});
        grp_en = NG'($urandom); casc_en = NPR'($urandom); mid_vis = NPR'($urandom);
      end
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule